// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block turns the syndromes of a binary BCH codeword over GF(2^13) into the error-locator polynomial sigma(x) and its degree. It runs the simplified Berlekamp-Massey recursion that binary codes allow. Only one row is computed per correction step, so a strength of t takes at most t steps. Each row keeps a step value mu, a discrepancy d, an order and a delta. The solver stops early once enough rows in a row-sequence have had a zero discrepancy. In a read path it sits between the syndrome stage and a root search. The root search and the bit flipping are not part of this block.

A run starts with a one-cycle strobe. The strobe carries the correction strength t and the packed vector of 2·T_MAX syndromes, and only the first 2t of them are used. The solver multiplies with one shared combinational GF(2^13) multiplier. Each field division is done as a Fermat inversion in a small sequential unit. The row that the next update refers to is tracked as a running best as rows complete, so no table of past rows is stored.

Top module: `bch_elp_solver`

## Requirements
- R1: After reset, busy and done are 0, every coefficient of sigma_out is 0 and degree_out is 0.
- R2: A start seen while busy is 0 is accepted, and busy is 1 in the next cycle. A start seen while busy is 1 is ignored and leaves the running computation and its result unchanged.
- R3: For a single bit error at position p with t ≥ 1, the result is sigma = 1 + α^p·x with degree 1. Syndrome S_j = α^(j·p) is packed at synd_in[(j-1)·13 +: 13]. Coefficient k of sigma is at sigma_out[k·13 +: 13]. The field is GF(2^13) with primitive polynomial x^13+x^4+x^3+x+1, and α = 2.
- R4: For e ≤ t distinct error positions p_1..p_e, with S_j the XOR of α^(j·p_n), the result is the product of (1 + α^(p_n)·x) and degree_out is e. This holds up to e = t = T_MAX.
- R5: When every syndrome is zero, the result is sigma = 1 with degree 0. Done is high exactly 2·h − 1 clock cycles after the cycle in which start is sampled, where c = t − 1 and h = c/2 + 2 for odd c, or h = c/2 + 1 for even c. This is the zero-discrepancy early exit.
- R6: Done is high for one cycle, with busy low in that same cycle. sigma_out and degree_out then hold their values until the next accepted start, whatever synd_in and t_in do.
- R7: When done is high, coefficient 0 of sigma is 1, and every coefficient above the reported degree is 0 for a correctable pattern.
- R8: Syndromes with index above 2t have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a solve when idle |
| t_in | input | $clog2(T_MAX+1) | Correction strength t, 1..T_MAX |
| synd_in | input | 2·T_MAX·M | Packed syndromes, S_j at bits (j-1)·M +: M |
| sigma_out | output | (T_MAX+1)·M | Packed locator coefficients, coefficient k at k·M +: M |
| degree_out | output | $clog2(2·T_MAX+3) | Degree of sigma |
| busy | output | 1 | High while a solve is in progress |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Some properties are checked by assertions on every cycle. These cover the start handshake raising busy, the one-cycle done pulse with busy low, coefficient 0 of sigma being 1 at done, and the outputs holding steady while idle. The field arithmetic can only be shown by the bench's scenarios, which build syndromes from chosen error positions and compare against the product of the matching linear factors. The same goes for the early-exit latency, for syndromes above 2t being ignored, and for a start that arrives during a run.

// File: rtl/bch_elp_pkg.sv
package bch_elp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_INV,
      ST_SCALE,
      ST_UPD,
      ST_COMMIT,
      ST_DISC
   } elp_state_e;

   // number of consecutive-style zero discrepancies that ends the search
   function automatic int zero_exit_limit(input int t_val, input int deg_val);
      int c;
      c = t_val - deg_val - 1;
      if (c < 0) c = 0;
      if ((c % 2) == 1) return c / 2 + 2;
      return c / 2 + 1;
   endfunction

endpackage

// File: rtl/bch_gf_mul.sv
module bch_gf_mul #(
   parameter int M = 13,
   parameter logic [M-1:0] POLY = 'h1B
) (
   input  logic [M-1:0] a,
   input  logic [M-1:0] b,
   output logic [M-1:0] y
);

   // Horner chain over the bits of b, most significant first
   for (genvar i = 0; i < M; i++) begin : g_step
      logic [M-1:0] prev;
      logic [M-1:0] dbl;
      logic [M-1:0] acc;
      if (i == 0) begin : g_first
         assign prev = '0;
      end else begin : g_next
         assign prev = g_step[i-1].acc;
      end
      assign dbl = prev[M-1] ? ({prev[M-2:0], 1'b0} ^ POLY) : {prev[M-2:0], 1'b0};
      assign acc = dbl ^ (b[M-1-i] ? a : '0);
   end

   assign y = g_step[M-1].acc;

endmodule

// File: rtl/bch_gf_inv.sv
module bch_gf_inv #(
   parameter int M = 13,
   parameter logic [M-1:0] POLY = 'h1B
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [M-1:0] a,
   output logic [M-1:0] y,
   output logic         rdy
);

   localparam int CNTW = $clog2(M);

   logic [M-1:0]    sq_q;
   logic [M-1:0]    prod_q;
   logic [M-1:0]    sq_n;
   logic [M-1:0]    prod_n;
   logic [CNTW-1:0] step_q;
   logic            run_q;

   // a^(2^M-2) = product of a^(2^k) for k = 1..M-1
   bch_gf_mul #(.M(M), .POLY(POLY)) u_sq (.a(sq_q), .b(sq_q), .y(sq_n));
   bch_gf_mul #(.M(M), .POLY(POLY)) u_pr (.a(prod_q), .b(sq_n), .y(prod_n));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq_q   <= '0;
         prod_q <= '0;
         step_q <= '0;
         run_q  <= 1'b0;
         rdy    <= 1'b0;
      end else begin
         rdy <= 1'b0;
         if (go) begin
            sq_q   <= a;
            prod_q <= M'(1);
            step_q <= '0;
            run_q  <= 1'b1;
         end else if (run_q) begin
            sq_q   <= sq_n;
            prod_q <= prod_n;
            step_q <= step_q + CNTW'(1);
            if (int'(step_q) == M - 2) begin
               run_q <= 1'b0;
               rdy   <= 1'b1;
            end
         end
      end
   end

   assign y = prod_q;

endmodule

// File: rtl/bch_elp_solver.sv
module bch_elp_solver
   import bch_elp_pkg::*;
#(
   parameter int M = 13,
   parameter logic [M-1:0] POLY = 'h1B,
   parameter int T_MAX = 24
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             start,
   input  logic [$clog2(T_MAX+1)-1:0]       t_in,
   input  logic [2*T_MAX*M-1:0]             synd_in,
   output logic [(T_MAX+1)*M-1:0]           sigma_out,
   output logic [$clog2(2*T_MAX+3)-1:0]     degree_out,
   output logic                             busy,
   output logic                             done
);

   localparam int NS  = 2 * T_MAX;
   localparam int NC  = T_MAX + 1;
   localparam int TW  = $clog2(T_MAX + 1);
   localparam int SW  = (NS > 1) ? $clog2(NS) : 1;
   localparam int CW  = $clog2(2 * T_MAX + 3);
   localparam int MUW = CW + 1;

   // elaboration-time parameter checks
   if (M < 3) begin : g_chk_m
      $error("bch_elp_solver: M must be at least 3");
   end
   if (T_MAX < 1) begin : g_chk_t
      $error("bch_elp_solver: T_MAX must be at least 1");
   end
   if (2 * T_MAX + 1 >= (1 << M) - 1) begin : g_chk_len
      $error("bch_elp_solver: T_MAX too large for the field size");
   end

   elp_state_e state_q;

   logic [M-1:0] syn_in_a [NS];
   logic [M-1:0] syn_q    [NS];
   logic [M-1:0] cur_sig  [NC];
   logic [M-1:0] nxt_sig  [NC];
   logic [M-1:0] bst_sig  [NC];

   logic [CW-1:0] t_q;
   logic [CW-1:0] row_q;
   logic [CW-1:0] k_q;
   logic [CW-1:0] zcnt_q;
   logic [CW-1:0] cur_deg;
   logic [CW-1:0] bst_deg;
   logic [M-1:0]  cur_d;
   logic [M-1:0]  bst_d;
   logic [M-1:0]  factor_q;
   logic [M-1:0]  acc_q;
   logic signed [MUW-1:0] bst_mu;
   logic signed [MUW-1:0] bst_delta;

   logic         inv_go;
   logic [M-1:0] inv_y;
   logic         inv_rdy;
   logic [M-1:0] mul_a;
   logic [M-1:0] mul_b;
   logic [M-1:0] mul_y;

   int mu_now;
   int dlt_now;
   int shift_now;
   int deg_new;
   int src_idx;
   int disc_j;
   int exit_lim;
   int t_eff;
   logic upd_ok;
   logic disc_ok;

   for (genvar g = 0; g < NS; g++) begin : g_syn
      assign syn_in_a[g] = synd_in[g*M +: M];
   end

   for (genvar g = 0; g < NC; g++) begin : g_sig
      assign sigma_out[g*M +: M] = cur_sig[g];
   end

   assign degree_out = cur_deg;

   bch_gf_mul #(.M(M), .POLY(POLY)) u_mul (.a(mul_a), .b(mul_b), .y(mul_y));

   bch_gf_inv #(.M(M), .POLY(POLY)) u_inv (
      .clk  (clk),
      .rst_n(rst_n),
      .go   (inv_go),
      .a    (bst_d),
      .y    (inv_y),
      .rdy  (inv_rdy)
   );

   // row bookkeeping and the shared multiplier's operand selection
   always_comb begin
      t_eff = int'(t_in);
      if (t_eff < 1) t_eff = 1;
      if (t_eff > T_MAX) t_eff = T_MAX;

      mu_now    = 2 * int'(row_q) - 2;
      dlt_now   = mu_now - int'(cur_deg);
      shift_now = mu_now - int'(bst_mu);
      deg_new   = int'(bst_deg) + shift_now;
      if (int'(cur_deg) > deg_new) deg_new = int'(cur_deg);

      src_idx = int'(k_q) - shift_now;
      upd_ok  = (src_idx >= 0) && (src_idx <= T_MAX);
      disc_j  = 2 * int'(row_q) - 1 - int'(k_q);
      disc_ok = (int'(k_q) <= int'(cur_deg)) && (int'(k_q) <= T_MAX) && (disc_j >= 1);
      exit_lim = zero_exit_limit(int'(t_q), int'(cur_deg));

      mul_a = '0;
      mul_b = '0;
      case (state_q)
         ST_SCALE: begin
            mul_a = cur_d;
            mul_b = inv_y;
         end
         ST_UPD: begin
            mul_a = factor_q;
            mul_b = upd_ok ? bst_sig[TW'(src_idx)] : '0;
         end
         ST_DISC: begin
            mul_a = disc_ok ? cur_sig[TW'(k_q)] : '0;
            mul_b = disc_ok ? syn_q[SW'(disc_j - 1)] : '0;
         end
         default: begin
            mul_a = '0;
            mul_b = '0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         busy      <= 1'b0;
         done      <= 1'b0;
         inv_go    <= 1'b0;
         t_q       <= '0;
         row_q     <= '0;
         k_q       <= '0;
         zcnt_q    <= '0;
         cur_deg   <= '0;
         bst_deg   <= '0;
         cur_d     <= '0;
         bst_d     <= '0;
         factor_q  <= '0;
         acc_q     <= '0;
         bst_mu    <= '0;
         bst_delta <= '0;
         for (int j = 0; j < NS; j++) syn_q[j] <= '0;
         for (int j = 0; j < NC; j++) begin
            cur_sig[j] <= '0;
            nxt_sig[j] <= '0;
            bst_sig[j] <= '0;
         end
      end else begin
         done   <= 1'b0;
         inv_go <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  for (int j = 0; j < NS; j++) syn_q[j] <= syn_in_a[j];
                  for (int j = 0; j < NC; j++) begin
                     cur_sig[j] <= (j == 0) ? M'(1) : '0;
                     bst_sig[j] <= (j == 0) ? M'(1) : '0;
                  end
                  t_q       <= CW'(t_eff);
                  row_q     <= CW'(1);
                  cur_deg   <= '0;
                  bst_deg   <= '0;
                  cur_d     <= syn_in_a[0];
                  bst_d     <= M'(1);
                  bst_mu    <= MUW'(-1);
                  bst_delta <= MUW'(-1);
                  zcnt_q    <= '0;
                  busy      <= 1'b1;
                  state_q   <= ST_ROW;
               end
            end

            ST_ROW: begin
               if (cur_d == '0) begin
                  zcnt_q <= zcnt_q + CW'(1);
                  if ((int'(zcnt_q) + 1 == exit_lim) || (row_q == t_q)) begin
                     busy    <= 1'b0;
                     done    <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     acc_q   <= syn_q[SW'(2 * int'(row_q))];
                     row_q   <= row_q + CW'(1);
                     k_q     <= CW'(1);
                     state_q <= ST_DISC;
                  end
               end else begin
                  inv_go  <= 1'b1;
                  state_q <= ST_INV;
               end
            end

            ST_INV: begin
               if (inv_rdy) state_q <= ST_SCALE;
            end

            ST_SCALE: begin
               factor_q <= mul_y;
               k_q      <= '0;
               state_q  <= ST_UPD;
            end

            ST_UPD: begin
               nxt_sig[TW'(k_q)] <= cur_sig[TW'(k_q)] ^ mul_y;
               if (int'(k_q) == T_MAX) state_q <= ST_COMMIT;
               else k_q <= k_q + CW'(1);
            end

            ST_COMMIT: begin
               if (dlt_now > int'(bst_delta)) begin
                  for (int j = 0; j < NC; j++) bst_sig[j] <= cur_sig[j];
                  bst_deg   <= cur_deg;
                  bst_d     <= cur_d;
                  bst_mu    <= MUW'(mu_now);
                  bst_delta <= MUW'(dlt_now);
               end
               for (int j = 0; j < NC; j++) cur_sig[j] <= nxt_sig[j];
               cur_deg <= CW'(deg_new);
               if (row_q == t_q) begin
                  busy    <= 1'b0;
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
               end else begin
                  acc_q   <= syn_q[SW'(2 * int'(row_q))];
                  row_q   <= row_q + CW'(1);
                  k_q     <= CW'(1);
                  state_q <= ST_DISC;
               end
            end

            ST_DISC: begin
               if (disc_ok) begin
                  acc_q <= acc_q ^ mul_y;
                  k_q   <= k_q + CW'(1);
               end else begin
                  cur_d   <= acc_q;
                  state_q <= ST_ROW;
               end
            end

            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bch_elp_solver_chk.sv
module bch_elp_solver_chk #(
   parameter int M = 13,
   parameter int T_MAX = 24
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         start,
   input logic                         busy,
   input logic                         done,
   input logic [(T_MAX+1)*M-1:0]       sigma_out,
   input logic [$clog2(2*T_MAX+3)-1:0] degree_out
);

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                   // R2

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R6

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                              // R6

   AST_SIGMA0_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sigma_out[M-1:0] == M'(1)));                        // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(sigma_out) && $stable(degree_out))); // R6

endmodule

bind bch_elp_solver bch_elp_solver_chk #(.M(M), .T_MAX(T_MAX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .sigma_out (sigma_out),
   .degree_out(degree_out)
);

// File: tb/bch_elp_solver_tb_top.sv
module bch_elp_solver_tb_top;

   localparam int M  = 13;
   localparam int T  = 24;
   localparam int NS = 2 * T;
   localparam int NC = T + 1;
   localparam int TW = $clog2(T + 1);
   localparam int CW = $clog2(2 * T + 3);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [TW-1:0]     t_in = '0;
   logic [NS*M-1:0]   synd_in = '0;
   logic [NC*M-1:0]   sigma_out;
   logic [CW-1:0]     degree_out;
   logic              busy;
   logic              done;

   int checks = 0;
   int fails  = 0;

   int          epos [T];
   int          ecnt;
   logic [M-1:0] exp_sig [NC];
   logic [NS*M-1:0] syn_vec;

   always #10 clk = ~clk;

   bch_elp_solver dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .t_in      (t_in),
      .synd_in   (synd_in),
      .sigma_out (sigma_out),
      .degree_out(degree_out),
      .busy      (busy),
      .done      (done)
   );

   // reference field product, x^13 = x^4+x^3+x+1
   function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
      logic [M-1:0] r;
      logic [M-1:0] x;
      r = '0;
      x = a;
      for (int i = 0; i < M; i++) begin
         if (b[i]) r ^= x;
         x = x[M-1] ? ({x[M-2:0], 1'b0} ^ 13'h001B) : {x[M-2:0], 1'b0};
      end
      return r;
   endfunction

   function automatic logic [M-1:0] apow(input int p);
      logic [M-1:0] r;
      r = 13'd1;
      for (int i = 0; i < p; i++) r = gmul(r, 13'd2);
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   // syndromes and expected locator from the error list; junk fills S_j for j > 2*tj
   task automatic build(input int tj, input bit junk);
      logic [M-1:0] s [NS];
      logic [M-1:0] nx [NC];
      for (int j = 0; j < NS; j++) s[j] = '0;
      for (int j = 0; j < NC; j++) exp_sig[j] = (j == 0) ? 13'd1 : 13'd0;
      for (int n = 0; n < ecnt; n++) begin
         logic [M-1:0] ap;
         logic [M-1:0] pw;
         ap = apow(epos[n]);
         pw = ap;
         for (int j = 0; j < NS; j++) begin
            s[j] ^= pw;
            pw = gmul(pw, ap);
         end
         for (int j = 0; j < NC; j++)
            nx[j] = exp_sig[j] ^ ((j > 0) ? gmul(ap, exp_sig[j-1]) : 13'd0);
         for (int j = 0; j < NC; j++) exp_sig[j] = nx[j];
      end
      for (int j = 0; j < NS; j++) begin
         if (junk && (j >= 2 * tj)) s[j] = 13'((j * 977 + 123) % 8191);
         syn_vec[j*M +: M] = s[j];
      end
   endtask

   task automatic run_solve(input int tj, input string req, output int lat);
      @(negedge clk);
      t_in    = TW'(tj);
      synd_in = syn_vec;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat   = 0;
      while (!done && lat < 6000) begin
         @(negedge clk);
         lat++;
      end
      if (!done) chk(1'b0, req, "no done", 64'(lat), 64'd0);
   endtask

   task automatic cmp_result(input string req, input int exp_deg);
      for (int j = 0; j < NC; j++)
         chk(sigma_out[j*M +: M] == exp_sig[j], req, $sformatf("sigma[%0d]", j),
             64'(sigma_out[j*M +: M]), 64'(exp_sig[j]));
      chk(int'(degree_out) == exp_deg, req, "degree", 64'(degree_out), 64'(exp_deg));
   endtask

   task automatic test_reset();
      chk(busy == 1'b0, "R1", "busy", 64'(busy), 64'd0);
      chk(done == 1'b0, "R1", "done", 64'(done), 64'd0);
      chk(sigma_out == '0, "R1", "sigma", 64'(sigma_out[63:0]), 64'd0);
      chk(degree_out == '0, "R1", "degree", 64'(degree_out), 64'd0);
   endtask

   task automatic test_single();
      int lat;
      ecnt = 1; epos[0] = 5;
      build(2, 1'b0);
      run_solve(2, "R3", lat);
      cmp_result("R3", 1);
      ecnt = 1; epos[0] = 4000;
      build(1, 1'b0);
      run_solve(1, "R3", lat);
      cmp_result("R3", 1);
   endtask

   task automatic test_multi();
      int lat;
      ecnt = 3; epos[0] = 0; epos[1] = 77; epos[2] = 4321;
      build(4, 1'b0);
      run_solve(4, "R4", lat);
      cmp_result("R4", 3);
      ecnt = 8;
      epos[0] = 3; epos[1] = 11; epos[2] = 19; epos[3] = 250;
      epos[4] = 1000; epos[5] = 2047; epos[6] = 5000; epos[7] = 8190;
      build(8, 1'b0);
      run_solve(8, "R4", lat);
      cmp_result("R4", 8);
      ecnt = 5;
      epos[0] = 1; epos[1] = 2; epos[2] = 3; epos[3] = 4; epos[4] = 8000;
      build(T, 1'b0);
      run_solve(T, "R4", lat);
      cmp_result("R7", 5);
      ecnt = T;
      for (int n = 0; n < T; n++) epos[n] = 13 + 331 * n;
      build(T, 1'b0);
      run_solve(T, "R4", lat);
      cmp_result("R4", T);
   endtask

   task automatic test_zero_exit();
      int lat;
      int c;
      int h;
      int tv [3];
      tv[0] = T; tv[1] = 5; tv[2] = 1;
      ecnt = 0;
      for (int n = 0; n < 3; n++) begin
         build(tv[n], 1'b0);
         c = tv[n] - 1;
         h = ((c % 2) == 1) ? c / 2 + 2 : c / 2 + 1;
         run_solve(tv[n], "R5", lat);
         chk(lat == 2 * h - 1, "R5", $sformatf("latency t=%0d", tv[n]), 64'(lat), 64'(2 * h - 1));
         cmp_result("R5", 0);
      end
   endtask

   task automatic test_junk_above_2t();
      int lat;
      ecnt = 1; epos[0] = 5;
      build(2, 1'b1);
      run_solve(2, "R8", lat);
      cmp_result("R8", 1);
      ecnt = 2; epos[0] = 600; epos[1] = 6000;
      build(3, 1'b1);
      run_solve(3, "R8", lat);
      cmp_result("R8", 2);
   endtask

   task automatic test_busy_ignore();
      logic [NS*M-1:0] first_vec;
      int lat;
      ecnt = 2; epos[0] = 10; epos[1] = 20;
      build(4, 1'b0);
      first_vec = syn_vec;
      @(negedge clk);
      t_in = TW'(4); synd_in = first_vec; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy after start", 64'(busy), 64'd1);
      @(negedge clk);
      @(negedge clk);
      synd_in = ~first_vec; t_in = TW'(1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 6000) begin
         @(negedge clk);
         lat++;
      end
      cmp_result("R2", 2);
   endtask

   task automatic test_hold();
      logic [NC*M-1:0] kept_sig;
      logic [CW-1:0]   kept_deg;
      int lat;
      ecnt = 3; epos[0] = 100; epos[1] = 200; epos[2] = 300;
      build(6, 1'b0);
      run_solve(6, "R6", lat);
      chk(busy == 1'b0, "R6", "busy with done", 64'(busy), 64'd0);
      kept_sig = sigma_out;
      kept_deg = degree_out;
      @(negedge clk);
      chk(done == 1'b0, "R6", "done width", 64'(done), 64'd0);
      synd_in = ~syn_vec;
      t_in    = TW'(2);
      repeat (6) @(negedge clk);
      chk(sigma_out == kept_sig, "R6", "sigma held", 64'(sigma_out[63:0]), 64'(kept_sig[63:0]));
      chk(degree_out == kept_deg, "R6", "degree held", 64'(degree_out), 64'(kept_deg));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_single();
      test_multi();
      test_zero_exit();
      test_junk_above_2t();
      test_busy_ignore();
      test_hold();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule